// File: doc/BRIEF.md
# Time-Matched Output Event Scheduler

This block takes timed commands and carries them out when a free-running timebase reaches a programmed value. Each command is a 7-bit tag with a 16-bit target time. The tag names an action and chooses which of two external timers the target time is compared against. Software writes the tag first and then the time word. The time write puts the complete command into a holding register. From there the command moves into one of eight free slots of an associative store.

The comparator is shared across the slots. In each state time (one clock) it looks at one slot, so it covers all eight slots in eight cycles. This is the same interval at which the reference timer advances, so a timer value is never missed. When the selected timer equals a slot's target time, the tagged action runs and the slot becomes free. An entry that never matches stays in the store until reset.

The actions are:
- drive one of six output pins high or low;
- set one of four software-timer expiry flags;
- pulse a reset request for the second timer;
- pulse a converter start.

Pin actions raise a pin-event interrupt. The other actions raise a software-timer interrupt. In both cases the interrupt fires only when the tag asks for one. Two status bits report how full the holding register and the store are.

Top module: `timed_event_sched`

## Requirements
- R1: After reset, pinOut, swFlag, holdFull and storeBusy are all 0, and no pulse output is high.
- R2: A tagWr latches tagIn. A later timeWr loads {latched tag, timeIn} into the holding register, and holdFull reads 1 on the next cycle. If a store slot is free, the command moves into it one cycle later and holdFull returns to 0.
- R3: A timeWr while the holding register is still full replaces the held command. The replaced command never executes.
- R4: Tag bit 6 selects the reference: 0 compares with timer1, 1 compares with timer2. A command executes within 9 cycles of its selected timer holding the target time. Slots are scanned one per cycle.
- R5: A stored command whose selected timer never equals its time stays pending and causes no action. A command that matches frees its slot for reuse.
- R6: Channels 0 to 5 (tag bits 3:0) drive pinOut[channel] to the value of tag bit 5. pinIrq pulses for one cycle when tag bit 4 is 1.
- R7: Channels 8 to 11 set swFlag[channel-8], which stays set until reset. swIrq pulses only when tag bit 4 is 1.
- R8: Channel 14 pulses t2Reset for one cycle. Channel 15 pulses adcStart for one cycle. Either one pulses swIrq when tag bit 4 is 1.
- R9: storeBusy is 1 whenever the holding register is full or all eight slots are occupied, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one state time |
| rstN | input | 1 | Active-low synchronous reset |
| tagWr | input | 1 | Latch a command tag |
| tagIn | input | 7 | Command tag |
| timeWr | input | 1 | Commit latched tag with target time |
| timeIn | input | 16 | Target time |
| timer1 | input | 16 | First timebase |
| timer2 | input | 16 | Second timebase |
| pinOut | output | 6 | Scheduled output pins |
| swFlag | output | 4 | Software-timer expiry flags |
| t2Reset | output | 1 | Second-timer reset pulse |
| adcStart | output | 1 | Converter start pulse |
| pinIrq | output | 1 | Pin-event interrupt pulse |
| swIrq | output | 1 | Software-timer interrupt pulse |
| holdFull | output | 1 | Holding register occupied |
| storeBusy | output | 1 | Holding register full or store full |

## Verification
The bench holds the timers away from every stored target for a long stretch. A design that compares only on timer changes, or that drops entries, would fire early or lose commands. The bench then loads the store to capacity and checks both status bits. It overwrites a parked command and confirms the replaced action never happens even when its time arrives. A design that queued both commands would move a pin it should not touch. The bench also runs a timer2-referenced command while timer1 sits on the target. This catches a wrong select bit. Each channel class is checked with and without the interrupt bit, which catches interrupts that ignore the tag.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int SLOTS   = 8;
  localparam int TAG_W   = 7;
  localparam int TIME_W  = 16;
  localparam int NUM_PIN = 6;
  localparam int NUM_SW  = 4;
  localparam int IDX_W   = $clog2(SLOTS);
  localparam int SEL_BIT = 6;
  localparam int SET_BIT = 5;
  localparam int IRQ_BIT = 4;
  localparam logic [3:0] SW_BASE = 4'h8;
  localparam logic [3:0] CH_T2   = 4'hE;
  localparam logic [3:0] CH_ADC  = 4'hF;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [TIME_W-1:0] when;
  } evs_cmd_t;

  typedef struct packed {
    logic             moveHold;
    logic [IDX_W-1:0] moveIdx;
    logic             freeScan;
  } evs_strobe_t;
endpackage

// File: rtl/evs_store.sv
module evs_store
  import evs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tagWr,
  input  logic [TAG_W-1:0]  tagIn,
  input  logic              timeWr,
  input  logic [TIME_W-1:0] timeIn,
  input  logic [TIME_W-1:0] timer1,
  input  logic [TIME_W-1:0] timer2,
  input  evs_strobe_t       strb,
  output logic              holdValid,
  output logic [SLOTS-1:0]  slotValid,
  output logic              scanHit,
  output logic [TAG_W-1:0]  scanTag
);
  logic [TAG_W-1:0] tagReg;
  evs_cmd_t         holdReg;
  evs_cmd_t         slots [SLOTS];
  logic [IDX_W-1:0] scanPtr;
  logic [TIME_W-1:0] refTime;

  always_comb begin
    scanTag = slots[scanPtr].tag;
    refTime = scanTag[SEL_BIT] ? timer2 : timer1;
    scanHit = slotValid[scanPtr] && (refTime == slots[scanPtr].when);
  end

  always_ff @(posedge clk) begin
    if (tagWr) tagReg <= tagIn;
    if (timeWr) holdReg <= '{tag: tagReg, when: timeIn};
    for (int i = 0; i < SLOTS; i++)
      if (strb.moveHold && strb.moveIdx == IDX_W'(i)) slots[i] <= holdReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      slotValid <= '0;
      scanPtr   <= '0;
    end else begin
      if (timeWr)             holdValid <= 1'b1;
      else if (strb.moveHold) holdValid <= 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
        if (strb.moveHold && strb.moveIdx == IDX_W'(i))
          slotValid[i] <= 1'b1;
        else if (strb.freeScan && scanPtr == IDX_W'(i))
          slotValid[i] <= 1'b0;
      end
      scanPtr <= (scanPtr == IDX_W'(SLOTS-1)) ? '0 : scanPtr + 1'b1;
    end
  end

  a_r2_commit_loads_hold: assert property (@(posedge clk) disable iff (!rstN)
    timeWr |=> holdValid);
  a_r2_move_empties_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.moveHold && !timeWr) |=> !holdValid);
  a_r4_scan_steps: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> scanPtr == (($past(scanPtr) == IDX_W'(SLOTS-1)) ? '0 : $past(scanPtr) + 1'b1));
  a_r5_match_frees: assert property (@(posedge clk) disable iff (!rstN)
    (scanHit && !strb.moveHold) |=> !slotValid[$past(scanPtr)]);

  for (genvar g = 0; g < SLOTS; g++) begin : g_keep
    a_r5_pending_kept: assert property (@(posedge clk) disable iff (!rstN)
      (slotValid[g] && !(scanHit && scanPtr == IDX_W'(g))) |=> slotValid[g]);
  end
endmodule

// File: rtl/evs_ctrl.sv
module evs_ctrl
  import evs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               holdValid,
  input  logic [SLOTS-1:0]   slotValid,
  input  logic               scanHit,
  input  logic [TAG_W-1:0]   scanTag,
  output evs_strobe_t        strb,
  output logic [NUM_PIN-1:0] pinOut,
  output logic [NUM_SW-1:0]  swFlag,
  output logic               t2Reset,
  output logic               adcStart,
  output logic               pinIrq,
  output logic               swIrq,
  output logic               holdFull,
  output logic               storeBusy
);
  logic [3:0] chan;
  logic       isPin, isSw, isT2, isAdc, anyFree;
  logic [IDX_W-1:0] freeIdx;

  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = SLOTS-1; i >= 0; i--)
      if (!slotValid[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    strb.moveHold = holdValid && anyFree;
    strb.moveIdx  = freeIdx;
    strb.freeScan = scanHit;
  end

  always_comb begin
    chan  = scanTag[3:0];
    isPin = chan < 4'(NUM_PIN);
    isSw  = (chan >= SW_BASE) && (chan < SW_BASE + 4'(NUM_SW));
    isT2  = chan == CH_T2;
    isAdc = chan == CH_ADC;
  end

  assign holdFull  = holdValid;
  assign storeBusy = holdValid | (&slotValid);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinOut   <= '0;
      swFlag   <= '0;
      t2Reset  <= 1'b0;
      adcStart <= 1'b0;
      pinIrq   <= 1'b0;
      swIrq    <= 1'b0;
    end else begin
      t2Reset  <= scanHit && isT2;
      adcStart <= scanHit && isAdc;
      pinIrq   <= scanHit && isPin && scanTag[IRQ_BIT];
      swIrq    <= scanHit && (isSw || isT2 || isAdc) && scanTag[IRQ_BIT];
      if (scanHit && isPin) pinOut[chan[$clog2(NUM_PIN)-1:0]] <= scanTag[SET_BIT];
      if (scanHit && isSw)  swFlag[chan[$clog2(NUM_SW)-1:0]] <= 1'b1;
    end
  end

  a_r6_pins_only_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    !scanHit |=> $stable(pinOut));
  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (swFlag & $past(swFlag)) == $past(swFlag));
  a_r8_t2_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    !scanHit |=> !t2Reset && !adcStart && !swIrq && !pinIrq);
endmodule

// File: rtl/timed_event_sched.sv
module timed_event_sched
  import evs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tagWr,
  input  logic [TAG_W-1:0]   tagIn,
  input  logic               timeWr,
  input  logic [TIME_W-1:0]  timeIn,
  input  logic [TIME_W-1:0]  timer1,
  input  logic [TIME_W-1:0]  timer2,
  output logic [NUM_PIN-1:0] pinOut,
  output logic [NUM_SW-1:0]  swFlag,
  output logic               t2Reset,
  output logic               adcStart,
  output logic               pinIrq,
  output logic               swIrq,
  output logic               holdFull,
  output logic               storeBusy
);
  evs_strobe_t      strb;
  logic             holdValid, scanHit;
  logic [SLOTS-1:0] slotValid;
  logic [TAG_W-1:0] scanTag;

  evs_store u_store (
    .clk(clk), .rstN(rstN), .tagWr(tagWr), .tagIn(tagIn),
    .timeWr(timeWr), .timeIn(timeIn), .timer1(timer1), .timer2(timer2),
    .strb(strb), .holdValid(holdValid), .slotValid(slotValid),
    .scanHit(scanHit), .scanTag(scanTag)
  );

  evs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .holdValid(holdValid), .slotValid(slotValid),
    .scanHit(scanHit), .scanTag(scanTag), .strb(strb),
    .pinOut(pinOut), .swFlag(swFlag), .t2Reset(t2Reset), .adcStart(adcStart),
    .pinIrq(pinIrq), .swIrq(swIrq), .holdFull(holdFull), .storeBusy(storeBusy)
  );
endmodule

// File: tb/timed_event_sched_tb.sv
`timescale 1ns/1ps
module timed_event_sched_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tagWr = 1'b0, timeWr = 1'b0;
  logic [6:0]  tagIn = '0;
  logic [15:0] timeIn = '0, timer1 = '0, timer2 = '0;
  logic [5:0]  pinOut;
  logic [3:0]  swFlag;
  logic        t2Reset, adcStart, pinIrq, swIrq, holdFull, storeBusy;
  int          nChecks = 0, nFails = 0;
  int          cT2 = 0, cAdc = 0, cPin = 0, cSw = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  timed_event_sched u_dut (
    .clk(clk), .rstN(rstN), .tagWr(tagWr), .tagIn(tagIn), .timeWr(timeWr),
    .timeIn(timeIn), .timer1(timer1), .timer2(timer2), .pinOut(pinOut),
    .swFlag(swFlag), .t2Reset(t2Reset), .adcStart(adcStart), .pinIrq(pinIrq),
    .swIrq(swIrq), .holdFull(holdFull), .storeBusy(storeBusy)
  );

  always @(negedge clk) begin
    if (t2Reset)  cT2++;
    if (adcStart) cAdc++;
    if (pinIrq)   cPin++;
    if (swIrq)    cSw++;
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic putCmd(input logic [6:0] tag, input logic [15:0] t);
    @(negedge clk); tagWr = 1'b1; tagIn = tag;
    @(negedge clk); tagWr = 1'b0; timeWr = 1'b1; timeIn = t;
    @(negedge clk); timeWr = 1'b0;
  endtask

  task automatic tReset();
    check("R1 pinOut", pinOut, 0);
    check("R1 swFlag", swFlag, 0);
    check("R1 status", {holdFull, storeBusy}, 0);
    check("R1 pulses", {t2Reset, adcStart, pinIrq, swIrq}, 0);
  endtask

  task automatic tEntryAndPin();
    int p0;
    p0 = cPin;
    putCmd(7'b0_1_1_0000, 16'h0100);
    check("R2 holdFull after commit", holdFull, 1);
    check("R9 busy while held", storeBusy, 1);
    idle(1);
    check("R2 hold drains to slot", holdFull, 0);
    check("R9 busy clear", storeBusy, 0);
    idle(20);
    check("R5 pending no action", pinOut, 0);
    timer1 = 16'h0100; idle(10);
    check("R4 R6 pin0 set", pinOut, 6'h01);
    check("R6 pinIrq with irq bit", cPin - p0, 1);
    p0 = cPin;
    putCmd(7'b0_0_0_0000, 16'h0101);
    timer1 = 16'h0101; idle(10);
    check("R6 pin0 cleared", pinOut, 0);
    check("R6 no pinIrq without bit", cPin - p0, 0);
  endtask

  task automatic tTimerSelect();
    putCmd(7'b1_1_0_0011, 16'h0200);
    timer1 = 16'h0200; timer2 = 16'h0000; idle(12);
    check("R4 timer1 ignored for sel=1", pinOut, 0);
    timer2 = 16'h0200; idle(10);
    check("R4 timer2 match", pinOut, 6'h08);
  endtask

  task automatic tSoftTimers();
    int s0;
    s0 = cSw;
    putCmd(7'b0_0_1_1010, 16'h0250);
    timer1 = 16'h0250; idle(10);
    check("R7 flag2 set", swFlag, 4'b0100);
    check("R7 swIrq with bit", cSw - s0, 1);
    s0 = cSw;
    putCmd(7'b0_0_0_1001, 16'h0260);
    timer1 = 16'h0260; idle(10);
    check("R7 flag1 set, flag2 kept", swFlag, 4'b0110);
    check("R7 no swIrq without bit", cSw - s0, 0);
  endtask

  task automatic tInternal();
    int t0, a0, s0;
    t0 = cT2; a0 = cAdc; s0 = cSw;
    putCmd(7'b0_0_0_1110, 16'h0270);
    timer1 = 16'h0270; idle(10);
    check("R8 t2Reset one pulse", cT2 - t0, 1);
    check("R8 no adcStart", cAdc - a0, 0);
    check("R8 no swIrq without bit", cSw - s0, 0);
    putCmd(7'b0_0_1_1111, 16'h0280);
    timer1 = 16'h0280; idle(10);
    check("R8 adcStart one pulse", cAdc - a0, 1);
    check("R8 swIrq with bit", cSw - s0, 1);
  endtask

  task automatic tFillOverwrite();
    timer1 = 16'h0300;
    for (int i = 0; i < 8; i++) putCmd(7'b0_0_0_0110, 16'h1000);
    idle(2);
    check("R9 busy when store full", storeBusy, 1);
    check("R2 hold empty after fill", holdFull, 0);
    putCmd(7'b0_1_0_0101, 16'h0400);
    idle(3);
    check("R2 hold stays full with no slot", holdFull, 1);
    putCmd(7'b0_1_0_0100, 16'h0500);
    timer1 = 16'h1000; idle(20);
    check("R5 slots freed, hold drained", {holdFull, storeBusy}, 0);
    timer1 = 16'h0400; idle(12);
    check("R3 overwritten command never runs", pinOut, 6'h08);
    timer1 = 16'h0500; idle(10);
    check("R3 replacement runs", pinOut, 6'h18);
  endtask

  initial begin
    fork
      begin
        idle(3); rstN = 1'b1; idle(1);
        tReset();
        tEntryAndPin();
        tTimerSelect();
        tSoftTimers();
        tInternal();
        tFillOverwrite();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          nChecks++; nFails++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule